// File: doc/BRIEF.md
# Auxiliary-Channel Request Dispatcher with I2C Bridging

The block takes requests arriving over a display link's auxiliary channel and carries each one out on the right back end. A request has a 4-bit command, a 20-bit address, a byte count and up to sixteen bytes of write data. It is accepted through a valid/ready handshake, and only while the block is idle. Native requests reach a byte-wide register port. The port is walked one byte per cycle over consecutive addresses.

I2C-over-AUX requests are turned into commands for a byte-level I2C master. That master accepts three operations: a start with address and direction, a one-byte transfer, and a stop. It answers each one with ack or nack. When the request finishes, the block raises a single done pulse. The pulse carries a native reply field, an I2C reply field and any bytes that were read.

The block keeps the I2C transaction open between middle-of-transaction requests. A chain of such requests that uses the same command and address therefore runs on one bus transaction. A new start is issued only when no transaction is open, or when the command or the full address differs from the previous chained request. A plain I2C request always closes the bus when it is done.

Top module: `aux_i2c_dispatch`

## Requirements
- R1: `reqReady` is high only while the block is idle, and a request is taken on a cycle with `reqValid` and `reqReady` both high. `doneValid` is a one-cycle pulse that carries the replies, and `reqReady` is high again on the next cycle. No register access and no I2C command is presented while `reqReady` is high.
- R2: Command codes are as follows. 8 is native write and 9 is native read. 0 is I2C write and 1 is I2C read. 4 is chained I2C write and 5 is chained I2C read. Any other code ends with `doneNatReply`=01 and `doneI2cReply`=00. It makes no register access, issues no I2C command, and leaves the open-transaction state and the last command and address unchanged.
- R3: A native request of length n accesses the register port once per cycle at addresses addr, addr+1, … modulo 2^20. A write drives byte k from `reqWrData[8k+7:8k]`. A read returns byte k in `doneRdData[8k+7:8k]`. Bytes that are not returned read as zero.
- R4: On a native request, the first access with `regErr` high is the last access and gives `doneNatReply`=01. If every access succeeds the reply is 00. A length of zero gives 01 with no access. A native request always returns `doneI2cReply`=00.
- R5: A requested length above 16 is treated as 16.
- R6: A plain I2C request (code 0 or 1) first issues a stop if a transaction is open. It then issues a start with address `reqAddr[6:0]` and the read flag `reqCmd[0]`. If the start is nacked, the reply is `doneI2cReply`=01, no further command follows, and the bus is left closed.
- R7: After an acked start, a plain I2C request issues one byte transfer per byte. The first nacked transfer ends the bytes, and the request then issues a stop with reply 01. If all transfers are acked, it issues a stop with reply 00. Read bytes k appear in `doneRdData[8k+7:8k]`.
- R8: A chained request (code 4 or 5) issues a start when no transaction is open. When one is open, it issues a stop and then a start if the 20-bit address or the command differs from the last chained request. Otherwise it issues no start and goes straight to the byte transfers.
- R9: A chained request that transfers all its bytes replies 00 and issues no stop, so the transaction stays open; a length of zero counts as success. A nacked transfer issues a stop and replies 01, and the bus ends closed. A nacked start replies 01 and the bus ends closed.
- R10: The I2C operation codes are 0 for start, 1 for byte transfer and 2 for stop. `i2cCmdValid` holds, with its operation, address and data stable, until the cycle in which `i2cRspValid` is high. A register access and an I2C command are never presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Block idle, request can be taken |
| reqCmd | input | 4 | Command code |
| reqAddr | input | 20 | Native address or I2C target address |
| reqLen | input | 8 | Byte count (clamped to 16) |
| reqWrData | input | 128 | Write bytes, byte k at bits 8k+7:8k |
| regEn | output | 1 | Register access this cycle |
| regWe | output | 1 | Access is a write |
| regAddr | output | 20 | Register address |
| regWrData | output | 8 | Register write byte |
| regRdData | input | 8 | Register read byte, same cycle |
| regErr | input | 1 | Access failed, same cycle |
| i2cCmdValid | output | 1 | I2C command presented |
| i2cCmdOp | output | 2 | 0 start, 1 byte transfer, 2 stop |
| i2cCmdAddr | output | 7 | Target address for a start |
| i2cCmdRead | output | 1 | Direction: 1 read |
| i2cCmdData | output | 8 | Byte to write on a transfer |
| i2cRspValid | input | 1 | Master answers the current command |
| i2cRspAck | input | 1 | 1 ack, 0 nack |
| i2cRspData | input | 8 | Byte read on a transfer |
| doneValid | output | 1 | Request finished |
| doneNatReply | output | 2 | Native reply, 00 ack, 01 nack |
| doneI2cReply | output | 2 | I2C reply, 00 ack, 01 nack |
| doneRdData | output | 128 | Read bytes |

## Verification
Two pairs of events can land on the same cycle. In the first, a failed access falls on the final byte of a native request, so the error and the normal completion meet on one cycle. The bench provokes this by placing the failing address window right at the last byte. In the second, a nack falls on the final transfer of a chained request, so closing the bus collides with leaving it open on success. The bench provokes this by nacking the last byte. In both cases the scoreboard must see exactly the failed access or the extra stop, and a 01 reply. A follow-up chained request then shows, through whether a fresh start appears, which transaction state was actually kept.

// File: rtl/aux_disp_pkg.sv
package aux_disp_pkg;

  localparam logic [1:0] OP_START = 2'd0;
  localparam logic [1:0] OP_XFER  = 2'd1;
  localparam logic [1:0] OP_STOP  = 2'd2;

  localparam logic [1:0] RPL_ACK  = 2'b00;
  localparam logic [1:0] RPL_NACK = 2'b01;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic advance;
    logic storeRd;
    logic recordLast;
    logic setOpen;
    logic clrOpen;
  } dpCtl_t;

  // status from datapath to control
  typedef struct packed {
    logic [3:0] cmd;
    logic       lenZero;
    logic       lastByte;
    logic       busOpen;
    logic       needRestart;
  } dpStat_t;

  function automatic logic cmdIsNative(input logic [3:0] c);
    return (c == 4'h8) || (c == 4'h9);
  endfunction

  function automatic logic cmdIsI2c(input logic [3:0] c);
    return (c[3] == 1'b0) && (c[1] == 1'b0);
  endfunction

  function automatic logic cmdIsMot(input logic [3:0] c);
    return c[2];
  endfunction

endpackage

// File: rtl/aux_disp_dp.sv
module aux_disp_dp
  import aux_disp_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int DATA_W    = 8,
  parameter int MAX_BYTES = 16,
  parameter int LEN_W     = 8,
  parameter int I2C_AW    = 7
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  dpCtl_t                      ctl,
  output dpStat_t                     stat,
  input  logic [3:0]                  reqCmd,
  input  logic [ADDR_W-1:0]           reqAddr,
  input  logic [LEN_W-1:0]            reqLen,
  input  logic [MAX_BYTES*DATA_W-1:0] reqWrData,
  output logic [ADDR_W-1:0]           regAddr,
  output logic [DATA_W-1:0]           regWrData,
  input  logic [DATA_W-1:0]           regRdData,
  output logic [I2C_AW-1:0]           i2cCmdAddr,
  output logic                        i2cCmdRead,
  output logic [DATA_W-1:0]           i2cCmdData,
  input  logic [DATA_W-1:0]           i2cRspData,
  output logic [MAX_BYTES*DATA_W-1:0] doneRdData
);

  localparam int CNT_W = $clog2(MAX_BYTES + 1);
  localparam int IDX_W = $clog2(MAX_BYTES);

  logic [3:0]        cmdQ, lastCmd;
  logic [ADDR_W-1:0] addrQ, lastAddr;
  logic [CNT_W-1:0]  lenQ, idx;
  logic              busOpen;
  logic [DATA_W-1:0] wrArr [MAX_BYTES];
  logic [DATA_W-1:0] rdArr [MAX_BYTES];
  logic [CNT_W-1:0]  lenClamp;
  logic [DATA_W-1:0] byteIn;
  logic [IDX_W-1:0]  slot;

  assign lenClamp = (reqLen > LEN_W'(MAX_BYTES)) ? CNT_W'(MAX_BYTES) : reqLen[CNT_W-1:0];
  assign byteIn   = cmdQ[3] ? regRdData : i2cRspData;
  assign slot     = idx[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdQ  <= '0;
      addrQ <= '0;
      lenQ  <= '0;
      idx   <= '0;
    end else if (ctl.load) begin
      cmdQ  <= reqCmd;
      addrQ <= reqAddr;
      lenQ  <= lenClamp;
      idx   <= '0;
    end else if (ctl.advance) begin
      idx <= idx + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busOpen  <= 1'b0;
      lastCmd  <= '0;
      lastAddr <= '0;
    end else begin
      if (ctl.setOpen)    busOpen <= 1'b1;
      else if (ctl.clrOpen) busOpen <= 1'b0;
      if (ctl.recordLast) begin
        lastCmd  <= cmdQ;
        lastAddr <= addrQ;
      end
    end
  end

  generate
    for (genvar g = 0; g < MAX_BYTES; g++) begin : g_bytes
      always_ff @(posedge clk) begin
        if (!rstN) begin
          wrArr[g] <= '0;
          rdArr[g] <= '0;
        end else if (ctl.load) begin
          wrArr[g] <= reqWrData[g*DATA_W +: DATA_W];
          rdArr[g] <= '0;
        end else if (ctl.storeRd && (slot == IDX_W'(g))) begin
          rdArr[g] <= byteIn;
        end
      end
      assign doneRdData[g*DATA_W +: DATA_W] = rdArr[g];
    end
  endgenerate

  assign regAddr    = addrQ + ADDR_W'(idx);
  assign regWrData  = wrArr[slot];
  assign i2cCmdData = wrArr[slot];
  assign i2cCmdAddr = addrQ[I2C_AW-1:0];
  assign i2cCmdRead = cmdQ[0];

  assign stat.cmd         = cmdQ;
  assign stat.lenZero     = (lenQ == '0);
  assign stat.lastByte    = ((idx + CNT_W'(1)) == lenQ);
  assign stat.busOpen     = busOpen;
  assign stat.needRestart = (addrQ != lastAddr) || (cmdQ != lastCmd);

endmodule

// File: rtl/aux_disp_ctrl.sv
module aux_disp_ctrl
  import aux_disp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  output logic       reqReady,
  output dpCtl_t     ctl,
  input  dpStat_t    stat,
  output logic       regEn,
  output logic       regWe,
  input  logic       regErr,
  output logic       i2cCmdValid,
  output logic [1:0] i2cCmdOp,
  input  logic       i2cRspValid,
  input  logic       i2cRspAck,
  output logic       doneValid,
  output logic [1:0] doneNatReply,
  output logic [1:0] doneI2cReply
);

  typedef enum logic [3:0] {
    S_IDLE, S_DISPATCH, S_NAT, S_PRESTOP, S_START,
    S_XFER, S_FAILSTOP, S_ENDSTOP, S_DONE
  } state_e;

  state_e     state, stateNext;
  logic [1:0] natQ, natN, i2cQ, i2cN;
  logic       isMot, isRead;

  assign isMot  = cmdIsMot(stat.cmd);
  assign isRead = stat.cmd[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      natQ  <= RPL_ACK;
      i2cQ  <= RPL_ACK;
    end else begin
      state <= stateNext;
      natQ  <= natN;
      i2cQ  <= i2cN;
    end
  end

  always_comb begin
    stateNext   = state;
    ctl         = '0;
    natN        = natQ;
    i2cN        = i2cQ;
    regEn       = 1'b0;
    i2cCmdValid = 1'b0;
    i2cCmdOp    = OP_START;
    unique case (state)
      S_IDLE: begin
        if (reqValid) begin
          ctl.load  = 1'b1;
          natN      = RPL_ACK;
          i2cN      = RPL_ACK;
          stateNext = S_DISPATCH;
        end
      end
      S_DISPATCH: begin
        if (cmdIsNative(stat.cmd)) begin
          if (stat.lenZero) begin
            natN      = RPL_NACK;
            stateNext = S_DONE;
          end else begin
            stateNext = S_NAT;
          end
        end else if (cmdIsI2c(stat.cmd)) begin
          if (!isMot) begin
            stateNext = stat.busOpen ? S_PRESTOP : S_START;
          end else if (!stat.busOpen) begin
            stateNext = S_START;
          end else if (stat.needRestart) begin
            stateNext = S_PRESTOP;
          end else begin
            ctl.recordLast = 1'b1;
            stateNext      = stat.lenZero ? S_DONE : S_XFER;
          end
        end else begin
          natN      = RPL_NACK;
          stateNext = S_DONE;
        end
      end
      S_NAT: begin
        regEn = 1'b1;
        if (regErr) begin
          natN      = RPL_NACK;
          stateNext = S_DONE;
        end else begin
          ctl.storeRd = isRead;
          ctl.advance = 1'b1;
          if (stat.lastByte) stateNext = S_DONE;
        end
      end
      S_PRESTOP: begin
        i2cCmdValid = 1'b1;
        i2cCmdOp    = OP_STOP;
        if (i2cRspValid) begin
          ctl.clrOpen = 1'b1;
          stateNext   = S_START;
        end
      end
      S_START: begin
        i2cCmdValid = 1'b1;
        i2cCmdOp    = OP_START;
        if (i2cRspValid) begin
          if (i2cRspAck) begin
            ctl.setOpen    = 1'b1;
            ctl.recordLast = isMot;
            if (stat.lenZero) stateNext = isMot ? S_DONE : S_ENDSTOP;
            else              stateNext = S_XFER;
          end else begin
            ctl.clrOpen = 1'b1;
            i2cN        = RPL_NACK;
            stateNext   = S_DONE;
          end
        end
      end
      S_XFER: begin
        i2cCmdValid = 1'b1;
        i2cCmdOp    = OP_XFER;
        if (i2cRspValid) begin
          if (i2cRspAck) begin
            ctl.storeRd = isRead;
            ctl.advance = 1'b1;
            if (stat.lastByte) stateNext = isMot ? S_DONE : S_ENDSTOP;
          end else begin
            stateNext = S_FAILSTOP;
          end
        end
      end
      S_FAILSTOP: begin
        i2cCmdValid = 1'b1;
        i2cCmdOp    = OP_STOP;
        if (i2cRspValid) begin
          ctl.clrOpen = 1'b1;
          i2cN        = RPL_NACK;
          stateNext   = S_DONE;
        end
      end
      S_ENDSTOP: begin
        i2cCmdValid = 1'b1;
        i2cCmdOp    = OP_STOP;
        if (i2cRspValid) begin
          ctl.clrOpen = 1'b1;
          stateNext   = S_DONE;
        end
      end
      S_DONE: stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  assign reqReady     = (state == S_IDLE);
  assign regWe        = regEn && !isRead;
  assign doneValid    = (state == S_DONE);
  assign doneNatReply = natQ;
  assign doneI2cReply = i2cQ;

endmodule

// File: rtl/aux_i2c_dispatch.sv
module aux_i2c_dispatch
  import aux_disp_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int DATA_W    = 8,
  parameter int MAX_BYTES = 16,
  parameter int LEN_W     = 8,
  parameter int I2C_AW    = 7
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        reqValid,
  output logic                        reqReady,
  input  logic [3:0]                  reqCmd,
  input  logic [ADDR_W-1:0]           reqAddr,
  input  logic [LEN_W-1:0]            reqLen,
  input  logic [MAX_BYTES*DATA_W-1:0] reqWrData,
  output logic                        regEn,
  output logic                        regWe,
  output logic [ADDR_W-1:0]           regAddr,
  output logic [DATA_W-1:0]           regWrData,
  input  logic [DATA_W-1:0]           regRdData,
  input  logic                        regErr,
  output logic                        i2cCmdValid,
  output logic [1:0]                  i2cCmdOp,
  output logic [I2C_AW-1:0]           i2cCmdAddr,
  output logic                        i2cCmdRead,
  output logic [DATA_W-1:0]           i2cCmdData,
  input  logic                        i2cRspValid,
  input  logic                        i2cRspAck,
  input  logic [DATA_W-1:0]           i2cRspData,
  output logic                        doneValid,
  output logic [1:0]                  doneNatReply,
  output logic [1:0]                  doneI2cReply,
  output logic [MAX_BYTES*DATA_W-1:0] doneRdData
);

  dpCtl_t  ctl;
  dpStat_t stat;

  aux_disp_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .reqReady     (reqReady),
    .ctl          (ctl),
    .stat         (stat),
    .regEn        (regEn),
    .regWe        (regWe),
    .regErr       (regErr),
    .i2cCmdValid  (i2cCmdValid),
    .i2cCmdOp     (i2cCmdOp),
    .i2cRspValid  (i2cRspValid),
    .i2cRspAck    (i2cRspAck),
    .doneValid    (doneValid),
    .doneNatReply (doneNatReply),
    .doneI2cReply (doneI2cReply)
  );

  aux_disp_dp #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .MAX_BYTES (MAX_BYTES),
    .LEN_W     (LEN_W),
    .I2C_AW    (I2C_AW)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .stat       (stat),
    .reqCmd     (reqCmd),
    .reqAddr    (reqAddr),
    .reqLen     (reqLen),
    .reqWrData  (reqWrData),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .regRdData  (regRdData),
    .i2cCmdAddr (i2cCmdAddr),
    .i2cCmdRead (i2cCmdRead),
    .i2cCmdData (i2cCmdData),
    .i2cRspData (i2cRspData),
    .doneRdData (doneRdData)
  );

endmodule

// File: rtl/aux_disp_chk.sv
module aux_disp_chk #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8,
  parameter int I2C_AW = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              regEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regErr,
  input logic              i2cCmdValid,
  input logic [1:0]        i2cCmdOp,
  input logic [I2C_AW-1:0] i2cCmdAddr,
  input logic [DATA_W-1:0] i2cCmdData,
  input logic              i2cRspValid,
  input logic              doneValid,
  input logic [1:0]        doneNatReply,
  input logic [1:0]        doneI2cReply
);

  p_accept_busy_r1: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> (!doneValid && reqReady));

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!regEn && !i2cCmdValid));

  p_nack_field_r2: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && doneNatReply != 2'b00) |-> (doneI2cReply == 2'b00));

  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (regEn && !regErr) |=> (!regEn || regAddr == ADDR_W'($past(regAddr) + 1'b1)));

  p_stop_on_err_r4: assert property (@(posedge clk) disable iff (!rstN)
    (regEn && regErr) |=> !regEn);

  p_cmd_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (i2cCmdValid && !i2cRspValid) |=>
      (i2cCmdValid && $stable(i2cCmdOp) && $stable(i2cCmdAddr) && $stable(i2cCmdData)));

  p_exclusive_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(regEn && i2cCmdValid));

endmodule

bind aux_i2c_dispatch aux_disp_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .I2C_AW (I2C_AW)
) u_chk (.*);

// File: tb/aux_i2c_dispatch_bench.sv
`timescale 1ns/1ps
module aux_i2c_dispatch_bench;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         reqValid = 1'b0;
  logic         reqReady;
  logic [3:0]   reqCmd = '0;
  logic [19:0]  reqAddr = '0;
  logic [7:0]   reqLen = '0;
  logic [127:0] reqWrData = '0;
  logic         regEn, regWe;
  logic [19:0]  regAddr;
  logic [7:0]   regWrData, regRdData;
  logic         regErr;
  logic         i2cCmdValid;
  logic [1:0]   i2cCmdOp;
  logic [6:0]   i2cCmdAddr;
  logic         i2cCmdRead;
  logic [7:0]   i2cCmdData;
  logic         i2cRspValid = 1'b0;
  logic         i2cRspAck = 1'b0;
  logic [7:0]   i2cRspData = '0;
  logic         doneValid;
  logic [1:0]   doneNatReply, doneI2cReply;
  logic [127:0] doneRdData;

  always #2 clk = ~clk;

  aux_i2c_dispatch u_aux_i2c_dispatch (.*);

  // register space model: fails in window 0xEEExx, read byte = addr[7:0]^3C
  assign regErr    = (regAddr[19:8] == 12'hEEE);
  assign regRdData = regAddr[7:0] ^ 8'h3C;

  int checks = 0;
  int fails = 0;
  int doneCnt = 0;
  int xferCnt = 0;
  int nackByte = 99;
  logic [6:0] nackAddr = 7'h7F;

  logic [35:0]  evQ[$];
  string        evTag[$];
  logic [131:0] dnQ[$];
  string        dnTag[$];

  bit          mOpen = 1'b0;
  logic [3:0]  mLastCmd = '0;
  logic [19:0] mLastAddr = '0;

  function automatic logic [35:0] evReg(input bit we, input logic [19:0] a, input logic [7:0] d);
    return {4'h1, 3'b0, we, a, d};
  endfunction

  function automatic logic [35:0] evI2c(input logic [1:0] op, input bit rd,
                                        input logic [6:0] a, input logic [7:0] d);
    return {4'h2, op, rd, 14'b0, a, d};
  endfunction

  function automatic logic [7:0] wb(input int k);
    return 8'(k * 7 + 17);
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [131:0] act, input logic [131:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic popEv(input logic [35:0] obs);
    if (evQ.size() == 0) begin
      check(1'b0, "R2", "unexpected bus event", {96'b0, obs}, '0);
    end else begin
      logic [35:0] e;
      string t;
      e = evQ.pop_front();
      t = evTag.pop_front();
      check(obs == e, t, "bus event", {96'b0, obs}, {96'b0, e});
    end
  endtask

  // monitor + I2C responder
  always @(negedge clk) begin
    if (rstN) begin
      if (regEn) popEv(evReg(regWe, regAddr, regWe ? regWrData : 8'h00));
      if (i2cRspValid) begin
        i2cRspValid = 1'b0;
      end else if (i2cCmdValid) begin
        case (i2cCmdOp)
          2'd0: begin
            popEv(evI2c(2'd0, i2cCmdRead, i2cCmdAddr, 8'h00));
            i2cRspAck = (i2cCmdAddr != nackAddr);
          end
          2'd1: begin
            popEv(evI2c(2'd1, i2cCmdRead, 7'h00, i2cCmdRead ? 8'h00 : i2cCmdData));
            i2cRspAck  = (xferCnt != nackByte);
            i2cRspData = 8'(8'hC0 + xferCnt);
            xferCnt++;
          end
          default: begin
            popEv(evI2c(i2cCmdOp, 1'b0, 7'h00, 8'h00));
            i2cRspAck = 1'b1;
          end
        endcase
        i2cRspValid = 1'b1;
      end
      if (doneValid) begin
        logic [131:0] obs;
        obs = {doneNatReply, doneI2cReply, doneRdData};
        if (dnQ.size() == 0) begin
          check(1'b0, "R1", "unexpected done", obs, '0);
        end else begin
          logic [131:0] e;
          string t;
          e = dnQ.pop_front();
          t = dnTag.pop_front();
          check(obs == e, t, "done reply/data", obs, e);
        end
        doneCnt++;
      end
    end
  end

  task automatic doReq(input logic [3:0] cmd, input logic [19:0] addr,
                       input int len, input string tag);
    int effLen;
    logic [127:0] wd;
    logic [127:0] expRd;
    logic [1:0] expNat, expI2c;
    bit rd;
    bit ok;
    int target;
    effLen = (len > 16) ? 16 : len;
    rd = cmd[0];
    wd = '0;
    for (int k = 0; k < 16; k++) wd[k*8 +: 8] = wb(k);
    expRd = '0;
    expNat = 2'b00;
    expI2c = 2'b00;
    if (cmd == 4'h8 || cmd == 4'h9) begin
      if (effLen == 0) expNat = 2'b01;
      for (int k = 0; k < effLen; k++) begin
        logic [19:0] a;
        a = addr + 20'(k);
        evQ.push_back(evReg(!rd, a, rd ? 8'h00 : wb(k)));
        evTag.push_back(tag);
        if (a[19:8] == 12'hEEE) begin
          expNat = 2'b01;
          break;
        end
        if (rd) expRd[k*8 +: 8] = a[7:0] ^ 8'h3C;
      end
    end else if (cmd == 4'h0 || cmd == 4'h1) begin
      if (mOpen) begin
        evQ.push_back(evI2c(2'd2, 1'b0, 7'h00, 8'h00));
        evTag.push_back(tag);
      end
      evQ.push_back(evI2c(2'd0, rd, addr[6:0], 8'h00));
      evTag.push_back(tag);
      if (addr[6:0] == nackAddr) begin
        expI2c = 2'b01;
      end else begin
        ok = 1'b1;
        for (int k = 0; k < effLen; k++) begin
          evQ.push_back(evI2c(2'd1, rd, 7'h00, rd ? 8'h00 : wb(k)));
          evTag.push_back(tag);
          if (k == nackByte) begin
            ok = 1'b0;
            break;
          end
          if (rd) expRd[k*8 +: 8] = 8'(8'hC0 + k);
        end
        evQ.push_back(evI2c(2'd2, 1'b0, 7'h00, 8'h00));
        evTag.push_back(tag);
        expI2c = ok ? 2'b00 : 2'b01;
      end
      mOpen = 1'b0;
    end else if (cmd == 4'h4 || cmd == 4'h5) begin
      ok = 1'b1;
      if (!mOpen || addr != mLastAddr || cmd != mLastCmd) begin
        if (mOpen) begin
          evQ.push_back(evI2c(2'd2, 1'b0, 7'h00, 8'h00));
          evTag.push_back(tag);
        end
        mOpen = 1'b0;
        evQ.push_back(evI2c(2'd0, rd, addr[6:0], 8'h00));
        evTag.push_back(tag);
        if (addr[6:0] == nackAddr) begin
          ok = 1'b0;
          expI2c = 2'b01;
        end else begin
          mOpen = 1'b1;
        end
      end
      if (ok) begin
        mLastCmd  = cmd;
        mLastAddr = addr;
        for (int k = 0; k < effLen; k++) begin
          evQ.push_back(evI2c(2'd1, rd, 7'h00, rd ? 8'h00 : wb(k)));
          evTag.push_back(tag);
          if (k == nackByte) begin
            evQ.push_back(evI2c(2'd2, 1'b0, 7'h00, 8'h00));
            evTag.push_back(tag);
            mOpen = 1'b0;
            expI2c = 2'b01;
            break;
          end
          if (rd) expRd[k*8 +: 8] = 8'(8'hC0 + k);
        end
      end
    end else begin
      expNat = 2'b01;
    end
    dnQ.push_back({expNat, expI2c, expRd});
    dnTag.push_back(tag);

    @(negedge clk);
    while (!reqReady) @(negedge clk);
    xferCnt   = 0;
    target    = doneCnt + 1;
    reqCmd    = cmd;
    reqAddr   = addr;
    reqLen    = 8'(len);
    reqWrData = wd;
    reqValid  = 1'b1;
    @(negedge clk);
    reqValid  = 1'b0;
    while (doneCnt < target) @(negedge clk);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R1 watchdog expired: actual hung expected done");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(reqReady && !doneValid && !regEn && !i2cCmdValid, "R1", "reset state",
          {128'b0, reqReady, doneValid, regEn, i2cCmdValid}, {128'b0, 4'b1000});

    // R3 native write / read with address wrap
    doReq(4'h8, 20'h00010, 4, "R3");
    doReq(4'h9, 20'hFFFFE, 5, "R3");
    // R4 error mid-request, error on the final byte, zero length
    doReq(4'h9, 20'hEEDFE, 4, "R4");
    doReq(4'h8, 20'hEEDFF, 2, "R4");
    doReq(4'h9, 20'h00100, 0, "R4");
    // R5 clamp
    doReq(4'h9, 20'h00200, 20, "R5");
    // R2 unknown command
    doReq(4'hA, 20'h00050, 3, "R2");

    // R6 / R7 plain I2C
    doReq(4'h0, 20'h00050, 3, "R7");
    doReq(4'h1, 20'h00050, 2, "R7");
    nackAddr = 7'h33;
    doReq(4'h1, 20'h00033, 2, "R6");
    nackAddr = 7'h7F;
    nackByte = 1;
    doReq(4'h0, 20'h00050, 3, "R7");
    nackByte = 99;
    doReq(4'h0, 20'h00050, 0, "R7");

    // R8 / R9 chained requests
    doReq(4'h4, 20'h00050, 2, "R8");
    doReq(4'h4, 20'h00050, 1, "R9");
    doReq(4'hF, 20'h00050, 1, "R2");
    doReq(4'h4, 20'h00050, 1, "R2");
    doReq(4'h9, 20'h00300, 1, "R3");
    doReq(4'h4, 20'h00050, 1, "R9");
    doReq(4'h5, 20'h00050, 2, "R8");
    doReq(4'h5, 20'h00051, 1, "R8");
    doReq(4'h5, 20'h80051, 1, "R8");
    doReq(4'h5, 20'h80051, 0, "R9");
    nackByte = 1;
    doReq(4'h5, 20'h80051, 2, "R9");
    nackByte = 99;
    doReq(4'h4, 20'h00022, 1, "R8");
    doReq(4'h1, 20'h00022, 1, "R6");
    nackAddr = 7'h44;
    doReq(4'h4, 20'h00044, 2, "R9");
    nackAddr = 7'h7F;
    doReq(4'h4, 20'h00045, 0, "R9");
    doReq(4'h4, 20'h00045, 1, "R9");

    repeat (4) @(negedge clk);
    check(evQ.size() == 0 && dnQ.size() == 0, "R10", "all expected items seen",
          {100'b0, 32'(evQ.size())}, '0);
    summary();
  end

endmodule